// File: doc/BRIEF.md
# Signed Word Multiply with Extension Register

This block executes a legacy word-multiply instruction. It takes two register operands as two's-complement values and forms their exact signed double-width product. The high word of the product is the destination-register result. The low word goes to a separate extension register output, which is called MQ here.

The block also keeps the per-thread overflow flags: a sticky summary-overflow bit and a plain overflow bit. It produces a 4-bit condition field for the record form of the instruction, and it updates the flags before it forms that field.

Operands and the two per-instruction control bits are presented with a one-cycle `start` pulse. A one-cycle `done` pulse marks the moment all results and flags are updated. Every output is a register and holds its value between updates.

A parameter selects the multiplier core:
- a single-cycle array multiply, or
- an iterative shift-add engine that uses one adder for the full word width.

Top module: `smul_mq_unit`

## Requirements
- R1: On `done`, `hi_word` equals bits 2W-1..W and `lo_word` equals bits W-1..0 of the exact signed product of `op_a` and `op_b`, where W is `WORD_W`.
- R2: `done` is high for exactly one cycle, in the cycle after the Nth rising edge that follows the edge accepting `start`. N is 1 when `ITERATIVE`=0 and `WORD_W`+1 when `ITERATIVE`=1.
- R3: With `ovf_en` set, overflow is detected when product bits 2W-1..W-1 are not all equal. On overflow, both `ovf` and `sum_ovf` are set.
- R4: With `ovf_en` set and no overflow, `ovf` is cleared and `sum_ovf` keeps its prior value.
- R5: With `ovf_en` clear, neither `ovf` nor `sum_ovf` changes.
- R6: With `rec_en` set, `cond` is set as follows:
  - bit 3 = `lo_word` negative;
  - bit 2 = `lo_word` positive and nonzero;
  - bit 1 = `lo_word` zero;
  - bit 0 = the `sum_ovf` value after this operation's flag update.
  Exactly one of bits 3..1 is set.
- R7: With `rec_en` clear, `cond` keeps its previous value.
- R8: No output changes except in a cycle where `done` is high.
- R9: In iterative mode, a `start` that arrives while an operation is in flight is ignored. The result reported is that of the operation already accepted.
- R10: After reset, all outputs are zero.
- R11: `sum_ovf` never returns to zero except through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse; operands and control bits are sampled with it |
| op_a | input | WORD_W | Multiplicand, two's complement |
| op_b | input | WORD_W | Multiplier, two's complement |
| ovf_en | input | 1 | Enable overflow-flag update |
| rec_en | input | 1 | Enable condition-field update |
| done | output | 1 | One-cycle completion pulse |
| hi_word | output | WORD_W | High product word (destination result) |
| lo_word | output | WORD_W | Low product word (MQ) |
| sum_ovf | output | 1 | Sticky summary overflow |
| ovf | output | 1 | Overflow of the most recent enabled operation |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The bench targets the products at the edge of the signed range:
- most-negative times most-negative, and most-negative times minus one;
- products of exactly plus and minus 2^31.

An unsigned multiply or a wrong negation of the magnitude product corrupts `hi_word` on these cases. An overflow test that looks only at the high word would miss +2^31 or wrongly flag -2^31.

Three more cases are checked:
- Records whose low word is zero while the high word is not, and the reverse. A condition field judged on the destination word gives the wrong LT/GT/EQ there.
- Records that overflow. If the field is formed before the flag update, it shows a stale SO bit.
- A second `start` during an iterative run. A core that reloads on it reports the wrong product.

// File: rtl/smul_pkg.sv
package smul_pkg;

   // Bit positions inside the condition field
   localparam int CF_LT = 3;
   localparam int CF_GT = 2;
   localparam int CF_EQ = 1;
   localparam int CF_SO = 0;
   localparam int CF_W  = 4;

   // Core variant selector values
   localparam int CORE_SINGLE = 0;
   localparam int CORE_ITER   = 1;

   typedef struct packed {
      logic so;
      logic ov;
   } ovf_flags_t;

   typedef struct packed {
      logic ovf_en;
      logic rec_en;
   } op_ctl_t;

endpackage

// File: rtl/smul_core_single.sv
module smul_core_single #(
   parameter int WORD_W = 32,
   localparam int PROD_W = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] mul_a,
   input  logic [WORD_W-1:0] mul_b,
   output logic              busy,
   output logic              prod_valid,
   output logic [PROD_W-1:0] product
);

   logic signed [PROD_W-1:0] a_ext;
   logic signed [PROD_W-1:0] b_ext;
   logic        [PROD_W-1:0] prod_q;
   logic                     valid_q;

   always_comb begin
      a_ext = {{WORD_W{mul_a[WORD_W-1]}}, mul_a};
      b_ext = {{WORD_W{mul_b[WORD_W-1]}}, mul_b};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prod_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= load;
         if (load) prod_q <= a_ext * b_ext;
      end
   end

   assign busy       = 1'b0;
   assign prod_valid = valid_q;
   assign product    = prod_q;

endmodule

// File: rtl/smul_core_iter.sv
module smul_core_iter #(
   parameter int WORD_W = 32,
   localparam int PROD_W = 2 * WORD_W,
   localparam int CNT_W  = $clog2(WORD_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] mul_a,
   input  logic [WORD_W-1:0] mul_b,
   output logic              busy,
   output logic              prod_valid,
   output logic [PROD_W-1:0] product
);

   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WORD_W - 1);

   logic              run_q;
   logic [CNT_W-1:0]  step_q;
   logic [PROD_W-1:0] acc_q;
   logic [PROD_W-1:0] mcand_q;
   logic [WORD_W-1:0] mplier_q;
   logic              neg_q;
   logic              valid_q;
   logic [WORD_W-1:0] mag_a;
   logic [WORD_W-1:0] mag_b;
   logic [PROD_W-1:0] acc_next;

   // Magnitudes as unsigned W-bit values; the most negative input maps to 2^(W-1)
   always_comb begin
      mag_a = mul_a[WORD_W-1] ? (~mul_a + 1'b1) : mul_a;
      mag_b = mul_b[WORD_W-1] ? (~mul_b + 1'b1) : mul_b;
      acc_next = mplier_q[0] ? (acc_q + mcand_q) : acc_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         step_q   <= '0;
         acc_q    <= '0;
         mcand_q  <= '0;
         mplier_q <= '0;
         neg_q    <= 1'b0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (load) begin
            run_q    <= 1'b1;
            step_q   <= '0;
            acc_q    <= '0;
            mcand_q  <= {{WORD_W{1'b0}}, mag_a};
            mplier_q <= mag_b;
            neg_q    <= mul_a[WORD_W-1] ^ mul_b[WORD_W-1];
         end else if (run_q) begin
            acc_q    <= acc_next;
            mcand_q  <= {mcand_q[PROD_W-2:0], 1'b0};
            mplier_q <= {1'b0, mplier_q[WORD_W-1:1]};
            step_q   <= step_q + 1'b1;
            if (step_q == LAST_STEP) begin
               run_q   <= 1'b0;
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign busy       = run_q;
   assign prod_valid = valid_q;
   assign product    = neg_q ? (~acc_q + 1'b1) : acc_q;

endmodule

// File: rtl/smul_flag_update.sv
module smul_flag_update
   import smul_pkg::*;
#(
   parameter int WORD_W = 32,
   localparam int PROD_W = 2 * WORD_W
) (
   input  logic [PROD_W-1:0] product,
   input  op_ctl_t           ctl,
   input  ovf_flags_t        flags_cur,
   input  logic [CF_W-1:0]   cond_cur,
   output ovf_flags_t        flags_nxt,
   output logic [CF_W-1:0]   cond_nxt
);

   logic [WORD_W:0]   top_bits;
   logic              fits;
   logic [WORD_W-1:0] low;
   logic              low_neg;
   logic              low_zero;

   always_comb begin
      top_bits = product[PROD_W-1:WORD_W-1];
      fits     = (top_bits == '0) || (top_bits == '1);
      low      = product[WORD_W-1:0];
      low_neg  = low[WORD_W-1];
      low_zero = (low == '0);

      // Flags first: the condition field copies the updated summary bit
      flags_nxt = flags_cur;
      if (ctl.ovf_en) begin
         flags_nxt.ov = !fits;
         if (!fits) flags_nxt.so = 1'b1;
      end

      cond_nxt = cond_cur;
      if (ctl.rec_en) begin
         cond_nxt[CF_LT] = low_neg;
         cond_nxt[CF_GT] = !low_neg && !low_zero;
         cond_nxt[CF_EQ] = low_zero;
         cond_nxt[CF_SO] = flags_nxt.so;
      end
   end

endmodule

// File: rtl/smul_mq_unit.sv
module smul_mq_unit
   import smul_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int ITERATIVE = CORE_ITER
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic              ovf_en,
   input  logic              rec_en,
   output logic              done,
   output logic [WORD_W-1:0] hi_word,
   output logic [WORD_W-1:0] lo_word,
   output logic              sum_ovf,
   output logic              ovf,
   output logic [3:0]        cond
);

   localparam int PROD_W = 2 * WORD_W;

   if (WORD_W < 2) begin : g_bad_width
      $error("smul_mq_unit: WORD_W must be at least 2");
   end
   if (ITERATIVE != CORE_SINGLE && ITERATIVE != CORE_ITER) begin : g_bad_mode
      $error("smul_mq_unit: ITERATIVE must be 0 or 1");
   end

   logic              core_busy;
   logic              core_valid;
   logic [PROD_W-1:0] core_prod;
   logic              accept;
   op_ctl_t           ctl_q;
   logic              ctl_ovf_en;
   ovf_flags_t        flags_q;
   ovf_flags_t        flags_nxt;
   logic [CF_W-1:0]   cond_q;
   logic [CF_W-1:0]   cond_nxt;
   logic [WORD_W-1:0] hi_q;
   logic [WORD_W-1:0] lo_q;
   logic              done_q;

   assign accept = start && !core_busy;

   if (ITERATIVE == CORE_ITER) begin : g_core_iter
      smul_core_iter #(.WORD_W(WORD_W)) u_core (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (accept),
         .mul_a      (op_a),
         .mul_b      (op_b),
         .busy       (core_busy),
         .prod_valid (core_valid),
         .product    (core_prod)
      );
   end else begin : g_core_single
      smul_core_single #(.WORD_W(WORD_W)) u_core (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (accept),
         .mul_a      (op_a),
         .mul_b      (op_b),
         .busy       (core_busy),
         .prod_valid (core_valid),
         .product    (core_prod)
      );
   end

   // Control bits travel with the accepted operation
   always_ff @(posedge clk) begin
      if (!rst_n) ctl_q <= '0;
      else if (accept) ctl_q <= '{ovf_en: ovf_en, rec_en: rec_en};
   end

   smul_flag_update #(.WORD_W(WORD_W)) u_flags (
      .product   (core_prod),
      .ctl       (ctl_q),
      .flags_cur (flags_q),
      .cond_cur  (cond_q),
      .flags_nxt (flags_nxt),
      .cond_nxt  (cond_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q    <= '0;
         lo_q    <= '0;
         flags_q <= '0;
         cond_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= core_valid;
         if (core_valid) begin
            hi_q    <= core_prod[PROD_W-1:WORD_W];
            lo_q    <= core_prod[WORD_W-1:0];
            flags_q <= flags_nxt;
            cond_q  <= cond_nxt;
         end
      end
   end

   assign ctl_ovf_en = ctl_q.ovf_en;
   assign done    = done_q;
   assign hi_word = hi_q;
   assign lo_word = lo_q;
   assign sum_ovf = flags_q.so;
   assign ovf     = flags_q.ov;
   assign cond    = cond_q;

endmodule

// File: rtl/smul_mq_unit_chk.sv
module smul_mq_unit_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         done,
   input logic [W-1:0] hi_word,
   input logic [W-1:0] lo_word,
   input logic         sum_ovf,
   input logic         ovf,
   input logic [3:0]   cond,
   input logic         ctl_ovf
);

   logic fits_w;
   assign fits_w = (hi_word == {W{lo_word[W-1]}});

   // R3: an overflowing product with the flag update enabled sets both flags
   a_r3_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ctl_ovf && !fits_w) |-> (ovf && sum_ovf));

   // R4: a fitting product with the flag update enabled leaves ovf clear
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ctl_ovf && fits_w) |-> !ovf);

   // R3: ovf can only be set together with the sticky bit
   a_r3_ov_implies_so: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> sum_ovf);

   // R11: the summary bit is sticky
   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      sum_ovf |=> sum_ovf);

   // R6: at most one of LT, GT and EQ
   a_r6_cond_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cond[3:1]));

   // R8: outputs move only with done
   a_r8_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(hi_word) && $stable(lo_word) && $stable(sum_ovf)
                 && $stable(ovf) && $stable(cond)));

endmodule

bind smul_mq_unit smul_mq_unit_chk #(.W(WORD_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .done    (done),
   .hi_word (hi_word),
   .lo_word (lo_word),
   .sum_ovf (sum_ovf),
   .ovf     (ovf),
   .cond    (cond),
   .ctl_ovf (ctl_ovf_en)
);

// File: tb/smul_mq_unit_test.sv
module smul_mq_unit_test;

   localparam int W   = 32;
   localparam int LAT = W + 1;   // default iterative core

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         ovf_en = 1'b0;
   logic         rec_en = 1'b0;
   logic         done;
   logic [W-1:0] hi_word;
   logic [W-1:0] lo_word;
   logic         sum_ovf;
   logic         ovf;
   logic [3:0]   cond;

   int checks = 0;
   int errors = 0;
   logic       m_so = 1'b0;
   logic       m_ov = 1'b0;
   logic [3:0] m_cond = 4'd0;

   always #4 clk = ~clk;   // 125 MHz

   smul_mq_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .ovf_en(ovf_en), .rec_en(rec_en), .done(done), .hi_word(hi_word),
      .lo_word(lo_word), .sum_ovf(sum_ovf), .ovf(ovf), .cond(cond)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      longint p;
      p = longint'($signed(a)) * longint'($signed(b));
      return p;
   endfunction

   // Advance the flag/condition model for one operation
   task automatic model_step(input logic [63:0] p, input logic oe, input logic re);
      logic fit;
      logic [W-1:0] lo;
      fit = (p[63:31] == '0) || (p[63:31] == '1);
      lo  = p[31:0];
      if (oe) begin
         m_ov = !fit;
         if (!fit) m_so = 1'b1;
      end
      if (re) m_cond = {lo[31], !lo[31] && (lo != 0), lo == 0, m_so};
   endtask

   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic oe, input logic re, input bit extra_start);
      logic [63:0] p;
      logic [W-1:0] hi0, lo0;
      logic [3:0] c0;
      int n;
      bit moved;
      p = ref_mul(a, b);
      hi0 = hi_word; lo0 = lo_word; c0 = cond;
      @(negedge clk);
      op_a = a; op_b = b; ovf_en = oe; rec_en = re; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n = 0; moved = 0;
      while (n < LAT + 5) begin
         if (extra_start && n == 3) begin
            op_a = ~a; op_b = b + 7; ovf_en = !oe; rec_en = !re; start = 1'b1;
         end
         @(posedge clk);
         n++;
         @(negedge clk);
         start = 1'b0;
         if (done) break;
         if (hi_word != hi0 || lo_word != lo0 || cond != c0) moved = 1;
      end
      model_step(p, oe, re);
      chk(n == LAT, "R2 latency", 64'(n), 64'(LAT));
      chk(!moved, "R8 outputs held before done", 64'(moved), 64'd0);
      chk(hi_word == p[63:32], extra_start ? "R9 hi ignored start" : "R1 hi_word",
          64'(hi_word), 64'(p[63:32]));
      chk(lo_word == p[31:0], "R1 lo_word", 64'(lo_word), 64'(p[31:0]));
      chk(ovf == m_ov, oe ? "R3/R4 ovf" : "R5 ovf held", 64'(ovf), 64'(m_ov));
      chk(sum_ovf == m_so, oe ? "R3/R4 sum_ovf" : "R5 sum_ovf held",
          64'(sum_ovf), 64'(m_so));
      chk(cond == m_cond, re ? "R6 cond" : "R7 cond held", 64'(cond), 64'(m_cond));
      @(negedge clk);
      chk(!done, "R2 done single cycle", 64'(done), 64'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      int seed;
      seed = $urandom(32'h5EED_0042);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      chk({done, hi_word, lo_word, sum_ovf, ovf, cond} == '0, "R10 reset outputs",
          {hi_word, lo_word}, 64'd0);

      // No-overflow work first, so R4 is seen with the sticky bit low
      run_op(32'd7, 32'hFFFF_FFFD, 1'b1, 1'b1, 0);          // -21
      run_op(32'd0, 32'h1234_5678, 1'b1, 1'b1, 0);          // EQ
      run_op(32'h0001_0000, 32'hFFFF_8000, 1'b1, 1'b1, 0);  // exactly -2^31, fits
      run_op(32'h0001_0000, 32'h0000_8000, 1'b0, 1'b0, 0);  // +2^31, flags disabled (R5, R7)
      chk(!sum_ovf && !ovf, "R5 no flag change when disabled", 64'(sum_ovf), 64'd0);
      run_op(32'h0001_0000, 32'h0000_8000, 1'b1, 1'b1, 0);  // +2^31 overflows, cond SO set
      run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 0);  // low word zero, hi nonzero
      run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 0);  // +2^31 from most negative
      run_op(32'd3, 32'd5, 1'b1, 1'b1, 0);                  // clears ovf, R11 keeps so
      chk(sum_ovf == 1'b1, "R11 sticky after clean op", 64'(sum_ovf), 64'd1);
      run_op(32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1, 0);
      run_op(32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b1, 1'b0, 1);  // R9 extra start mid-run

      for (int i = 0; i < 300; i++) begin
         logic [W-1:0] a, b;
         int kind;
         kind = int'($urandom % 4);
         a = $urandom;
         b = $urandom;
         if (kind == 1) begin
            a = {{16{a[15]}}, a[15:0]};
            b = {{16{b[15]}}, b[15:0]};
         end else if (kind == 2) begin
            a = (a[0]) ? 32'h8000_0000 : 32'hFFFF_FFFF;
            b = {{24{b[7]}}, b[7:0]};
         end
         run_op(a, b, 1'(($urandom % 3) != 0), 1'(($urandom % 3) != 0), 0);
      end

      // R10 reset clears everything, including the sticky bit
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk({hi_word, lo_word, sum_ovf, ovf, cond} == '0, "R10 reset clears sticky",
          64'(sum_ovf), 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule